// File: doc/BRIEF.md
# Video Pixel-Per-Clock Downsizer (Two Pixels In, One Pixel Out)

This block sits between a video source that delivers two 4:2:2 pixels in every stream beat and a sink that takes one pixel per clock. Each input word is 48 bits wide. The two 16-bit pixels occupy the low 32 bits, with the earlier (left-most) pixel in bits 15:0. Bits 47:32 are padding and carry nothing. The block drops the padding, splits the pair and emits the two pixels in scanline order on a 16-bit output stream.

The start-of-frame flag (sideband user bit 0) and the end-of-line flag travel with the pixels. Start-of-frame lands on the first pixel of a pair and end-of-line on the second. Both sides use a valid/ready handshake in a single clock domain. With an unstalled sink the block delivers one pixel every clock and so accepts a new input word every second clock. Lines must hold an even number of pixels.

Top module: `pixdown_2to1`

## Requirements
- R1: While `rst` is high at a rising edge, and in the cycle after that edge, `m_tvalid` is 0 and `s_tready` is 1.
- R2: An accepted input word produces its pixels in order. `s_tdata[15:0]` appears on `m_tdata` first and `s_tdata[31:16]` second. The first of them appears in the cycle after acceptance.
- R3: Bits 47:32 of `s_tdata` have no effect on any output.
- R4: Every accepted input word yields exactly two output beats, and no output beat exists without an accepted word.
- R5: `m_tuser` equals `s_tuser[0]` of the source word on the first output beat of that word and is 0 on the second. `s_tuser` bits above bit 0 have no effect.
- R6: `m_tlast` equals `s_tlast` of the source word on the second output beat of that word and is 0 on the first.
- R7: `s_tready` is 1 only when no pixel is held, or when the last held pixel is being taken in the same cycle. It is 0 whenever `m_tvalid` is 1 and `m_tready` is 0.
- R8: While `m_tvalid` is 1 and `m_tready` is 0, the next cycle keeps `m_tvalid` at 1 and holds `m_tdata`, `m_tuser` and `m_tlast` unchanged.
- R9: With `s_tvalid` and `m_tready` held at 1, the block outputs one beat per clock and accepts one input word every two clocks.
- R10: A reset in the middle of a pair discards the held pixel. The first output after reset is the bits 15:0 pixel of the next accepted word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| s_tdata | input | 48 | Input word: pixel 0 in bits 15:0, pixel 1 in bits 31:16, padding in bits 47:32 |
| s_tuser | input | 4 | Input sideband; bit 0 is start of frame |
| s_tlast | input | 1 | Input end of line |
| s_tvalid | input | 1 | Input word valid |
| s_tready | output | 1 | Block can take an input word |
| m_tdata | output | 16 | Output pixel |
| m_tuser | output | 1 | Output start of frame |
| m_tlast | output | 1 | Output end of line |
| m_tvalid | output | 1 | Output pixel valid |
| m_tready | input | 1 | Sink takes the output pixel |

## Verification
The assertions assume that the source keeps `s_tdata`, `s_tuser` and `s_tlast` steady while `s_tvalid` waits for `s_tready`. They also assume that lines contain whole pixel pairs, so end-of-line only ever belongs to a second pixel. The stimulus generator builds each word once and holds it on the port until the handshake completes. It places end-of-line on every fourth word and start-of-frame on the first word of every twelve, so lines are always eight pixels long. The padding bits and the upper user bits are driven with random values. Source and sink stalls are drawn independently of each other, so every mix of stalls occurs on both sides.

// File: rtl/dsz_pkg.sv
`timescale 1ns/1ps
package dsz_pkg;

    // Default geometry of the stream
    localparam int DEF_PIX_W  = 16;
    localparam int DEF_PPC    = 2;
    localparam int DEF_IN_W   = 48;
    localparam int DEF_USER_W = 4;

    // Occupancy of the pair holding register
    typedef enum logic {
        BUF_IDLE = 1'b0,
        BUF_HELD = 1'b1
    } buf_state_e;

    // Width of a lane index for a given lane count
    function automatic int lane_idx_w(input int ppc);
        return (ppc > 1) ? $clog2(ppc) : 1;
    endfunction

endpackage

// File: rtl/dsz_unpack.sv
`timescale 1ns/1ps
module dsz_unpack #(
    parameter int PIX_W = dsz_pkg::DEF_PIX_W,
    parameter int PPC   = dsz_pkg::DEF_PPC
) (
    input  logic [PIX_W*PPC-1:0]      packed_in,
    output logic [PPC-1:0][PIX_W-1:0] lanes_out
);
    // The least significant lane is the earliest pixel in the scanline
    for (genvar g = 0; g < PPC; g++) begin : g_lane
        assign lanes_out[g] = packed_in[g*PIX_W +: PIX_W];
    end
endmodule

// File: rtl/dsz_pair_buf.sv
`timescale 1ns/1ps
module dsz_pair_buf #(
    parameter int PIX_W = dsz_pkg::DEF_PIX_W,
    parameter int PPC   = dsz_pkg::DEF_PPC,
    localparam int PH_W = dsz_pkg::lane_idx_w(PPC)
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      in_valid,
    output logic                      in_ready,
    input  logic [PPC-1:0][PIX_W-1:0] in_lanes,
    input  logic                      in_sof,
    input  logic                      in_eol,
    input  logic                      advance,
    output logic                      held,
    output logic [PH_W-1:0]           phase,
    output logic [PPC-1:0][PIX_W-1:0] lanes,
    output logic                      sof,
    output logic                      eol
);
    import dsz_pkg::*;

    buf_state_e state_q;
    logic       on_last_lane;
    logic       load;

    assign on_last_lane = (phase == PH_W'(PPC-1));
    assign in_ready     = (state_q == BUF_IDLE) || (on_last_lane && advance);
    assign load         = in_valid && in_ready;
    assign held         = (state_q == BUF_HELD);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= BUF_IDLE;
            phase   <= '0;
        end else if (load) begin
            state_q <= BUF_HELD;
            phase   <= '0;
        end else if (advance && held) begin
            if (on_last_lane) begin
                state_q <= BUF_IDLE;
                phase   <= '0;
            end else begin
                phase <= phase + PH_W'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (load) begin
            lanes <= in_lanes;
            sof   <= in_sof;
            eol   <= in_eol;
        end
    end

    // A freshly loaded pair always starts on its lowest lane (R2, R10)
    a_r10_load_starts_low: assert property (@(posedge clk) disable iff (rst)
        load |=> held && (phase == '0));

    // An emptied buffer must have taken the last lane (R4)
    a_r4_drain_on_last: assert property (@(posedge clk) disable iff (rst)
        held && !load |=> held || ($past(on_last_lane) && $past(advance)));
endmodule

// File: rtl/dsz_lane_mux.sv
`timescale 1ns/1ps
module dsz_lane_mux #(
    parameter int PIX_W = dsz_pkg::DEF_PIX_W,
    parameter int PPC   = dsz_pkg::DEF_PPC,
    localparam int PH_W = dsz_pkg::lane_idx_w(PPC)
) (
    input  logic [PPC-1:0][PIX_W-1:0] lanes,
    input  logic [PH_W-1:0]           phase,
    input  logic                      held,
    input  logic                      sof,
    input  logic                      eol,
    output logic [PIX_W-1:0]          pix,
    output logic                      pix_sof,
    output logic                      pix_eol,
    output logic                      pix_valid
);
    always_comb begin
        pix = '0;
        for (int i = 0; i < PPC; i++) begin
            if (phase == PH_W'(i)) pix = lanes[i];
        end
    end

    // Frame start rides the first lane, line end rides the last lane
    assign pix_sof   = sof && (phase == '0);
    assign pix_eol   = eol && (phase == PH_W'(PPC-1));
    assign pix_valid = held;
endmodule

// File: rtl/pixdown_2to1.sv
`timescale 1ns/1ps
module pixdown_2to1 #(
    parameter int IN_W   = dsz_pkg::DEF_IN_W,
    parameter int PIX_W  = dsz_pkg::DEF_PIX_W,
    parameter int PPC    = dsz_pkg::DEF_PPC,
    parameter int USER_W = dsz_pkg::DEF_USER_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [IN_W-1:0]   s_tdata,
    input  logic [USER_W-1:0] s_tuser,
    input  logic              s_tlast,
    input  logic              s_tvalid,
    output logic              s_tready,
    output logic [PIX_W-1:0]  m_tdata,
    output logic              m_tuser,
    output logic              m_tlast,
    output logic              m_tvalid,
    input  logic              m_tready
);
    localparam int USED_W = PIX_W * PPC;
    localparam int PH_W   = dsz_pkg::lane_idx_w(PPC);

    typedef struct packed {
        logic [PPC-1:0][PIX_W-1:0] lanes;
        logic                      sof;
        logic                      eol;
    } pair_t;

    pair_t                     in_pair;
    logic [PPC-1:0][PIX_W-1:0] held_lanes;
    logic [PH_W-1:0]           phase;
    logic                      held, held_sof, held_eol;
    logic                      out_fire;
    logic                      pad_unused;

    // Padding and the upper sideband bits carry nothing
    assign pad_unused = ^{s_tdata[IN_W-1:USED_W], s_tuser[USER_W-1:1]};

    assign in_pair.sof = s_tuser[0];
    assign in_pair.eol = s_tlast;
    assign out_fire    = m_tvalid && m_tready;

    dsz_unpack #(.PIX_W(PIX_W), .PPC(PPC)) u_unpack (
        .packed_in (s_tdata[USED_W-1:0]),
        .lanes_out (in_pair.lanes)
    );

    dsz_pair_buf #(.PIX_W(PIX_W), .PPC(PPC)) u_buf (
        .clk      (clk),
        .rst      (rst),
        .in_valid (s_tvalid),
        .in_ready (s_tready),
        .in_lanes (in_pair.lanes),
        .in_sof   (in_pair.sof),
        .in_eol   (in_pair.eol),
        .advance  (out_fire),
        .held     (held),
        .phase    (phase),
        .lanes    (held_lanes),
        .sof      (held_sof),
        .eol      (held_eol)
    );

    dsz_lane_mux #(.PIX_W(PIX_W), .PPC(PPC)) u_mux (
        .lanes     (held_lanes),
        .phase     (phase),
        .held      (held),
        .sof       (held_sof),
        .eol       (held_eol),
        .pix       (m_tdata),
        .pix_sof   (m_tuser),
        .pix_eol   (m_tlast),
        .pix_valid (m_tvalid)
    );

    a_r1_idle_after_reset: assert property (@(posedge clk)
        $past(rst) |-> !m_tvalid && s_tready);

    a_r2_low_pixel_first: assert property (@(posedge clk) disable iff (rst)
        s_tvalid && s_tready |=> m_tvalid && (m_tdata == $past(s_tdata[PIX_W-1:0])));

    a_r5_sof_once: assert property (@(posedge clk) disable iff (rst)
        out_fire && m_tuser |=> !m_tuser);

    a_r6_eol_once: assert property (@(posedge clk) disable iff (rst)
        out_fire && m_tlast |=> !m_tlast);

    a_r7_no_accept_on_stall: assert property (@(posedge clk) disable iff (rst)
        m_tvalid && !m_tready |-> !s_tready);

    a_r8_hold_stable: assert property (@(posedge clk) disable iff (rst)
        m_tvalid && !m_tready |=> m_tvalid && $stable(m_tdata)
                                  && $stable(m_tuser) && $stable(m_tlast));
endmodule

// File: tb/tb_pixdown_2to1.sv
`timescale 1ns/1ps
module tb_pixdown_2to1;
    localparam int LINE_BEATS  = 4;
    localparam int FRAME_BEATS = 12;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [47:0] s_tdata = '0;
    logic [3:0]  s_tuser = '0;
    logic        s_tlast = 1'b0;
    logic        s_tvalid = 1'b0;
    logic        s_tready;
    logic [15:0] m_tdata;
    logic        m_tuser, m_tlast, m_tvalid;
    logic        m_tready = 1'b0;

    always #2.5 clk = ~clk;

    pixdown_2to1 dut (
        .clk(clk), .rst(rst),
        .s_tdata(s_tdata), .s_tuser(s_tuser), .s_tlast(s_tlast),
        .s_tvalid(s_tvalid), .s_tready(s_tready),
        .m_tdata(m_tdata), .m_tuser(m_tuser), .m_tlast(m_tlast),
        .m_tvalid(m_tvalid), .m_tready(m_tready)
    );

    int checks = 0;
    int errors = 0;
    bit done = 0;
    int gen_beat = 0;
    bit pending = 0;
    int out_count = 0;
    int in_count = 0;
    logic [17:0] exp_q[$];
    bit prev_stall = 0;
    logic [17:0] prev_beat = '0;

    task automatic check(input bit ok, input string tag, input logic [31:0] got,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s got %h exp %h", tag, got, exp);
        end
    endtask

    // One clock: drive at the falling edge, check after settling
    task automatic step(input bit want_in, input bit sink_rdy);
        logic [15:0] p0, p1;
        logic [17:0] got, exp;
        @(negedge clk);
        if (!pending) begin
            if (want_in) begin
                p0 = 16'(gen_beat * 2) ^ 16'h5A00;
                p1 = 16'(gen_beat * 2 + 1) ^ 16'h5A00;
                s_tdata  = {16'($urandom), p1, p0};
                s_tuser  = {3'($urandom), 1'((gen_beat % FRAME_BEATS) == 0)};
                s_tlast  = ((gen_beat % LINE_BEATS) == LINE_BEATS - 1);
                s_tvalid = 1'b1;
                pending  = 1;
                gen_beat++;
            end else begin
                s_tvalid = 1'b0;
            end
        end
        m_tready = sink_rdy;
        #1;
        got = {m_tdata, m_tuser, m_tlast};
        check(s_tready == ((exp_q.size() == 0) || (exp_q.size() == 1 && m_tready)),
              "R7 s_tready", 32'(s_tready), 32'(exp_q.size()));
        check(m_tvalid == (exp_q.size() != 0), "R4 m_tvalid",
              32'(m_tvalid), 32'(exp_q.size()));
        if (prev_stall)
            check(m_tvalid && got == prev_beat, "R8 stall hold", 32'(got), 32'(prev_beat));
        if (m_tvalid && exp_q.size() != 0) begin
            exp = exp_q[0];
            check(got[17:2] == exp[17:2], "R2/R3 pixel", 32'(got[17:2]), 32'(exp[17:2]));
            check(got[1] == exp[1], "R5 tuser", 32'(got[1]), 32'(exp[1]));
            check(got[0] == exp[0], "R6 tlast", 32'(got[0]), 32'(exp[0]));
        end
        prev_stall = m_tvalid && !m_tready;
        prev_beat  = got;
        if (m_tvalid && m_tready) begin
            if (exp_q.size() != 0) void'(exp_q.pop_front());
            out_count++;
        end
        if (s_tvalid && s_tready) begin
            exp_q.push_back({s_tdata[15:0], s_tuser[0], 1'b0});
            exp_q.push_back({s_tdata[31:16], 1'b0, s_tlast});
            pending = 0;
            in_count++;
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        s_tvalid = 1'b0;
        pending = 0;
        exp_q.delete();
        prev_stall = 0;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        #1;
        check(!m_tvalid, "R1 m_tvalid after reset", 32'(m_tvalid), 0);
        check(s_tready, "R1 s_tready after reset", 32'(s_tready), 1);
    endtask

    initial begin
        int oc0, ic0;
        do_reset();

        // R9: continuous flow, sink always ready
        for (int i = 0; i < 4; i++) step(1, 1);
        oc0 = out_count; ic0 = in_count;
        for (int i = 0; i < 40; i++) step(1, 1);
        check(out_count - oc0 == 40, "R9 output rate", 32'(out_count - oc0), 40);
        check(in_count - ic0 == 20, "R9 input rate", 32'(in_count - ic0), 20);

        // Sink stalls only
        for (int i = 0; i < 200; i++) step(1, 1'($urandom % 3 != 0));
        // Source gaps only
        for (int i = 0; i < 200; i++) step(1'($urandom % 2), 1);
        // Both sides random
        for (int i = 0; i < 600; i++) step(1'($urandom % 3 != 0), 1'($urandom % 2));
        for (int i = 0; i < 8; i++) step(0, 1);

        // R10: reset after only the first pixel of a pair was taken
        step(1, 0);
        step(0, 1);
        check(exp_q.size() == 1, "R10 mid-pair setup", 32'(exp_q.size()), 1);
        do_reset();
        for (int i = 0; i < 3; i++) step(0, 1);
        check(!m_tvalid, "R10 held pixel discarded", 32'(m_tvalid), 0);
        for (int i = 0; i < 30; i++) step(1, 1'($urandom % 2));
        for (int i = 0; i < 8; i++) step(0, 1);
        check(exp_q.size() == 0, "R4 all pixels drained", 32'(exp_q.size()), 0);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule